// File: doc/BRIEF.md
# Programmable Interval Alarm Timer

This block counts periods of a selectable time base and raises an alarm once a programmed number of periods has gone by. A 128 Hz enable pulse, one core-clock cycle wide and taken from a 32.768 kHz source, drives it. From that pulse the block derives four time bases: the raw 1/128 s tick, seconds, minutes and hours. Seconds, minutes and hours come from a chain of prescalers whose lengths are parameters.

Software writes a configuration word in one cycle. The word holds an 8-bit interval, a 2-bit time base, an enable and a repeat bit. The word is held in a staging register and takes effect on the next 128 Hz pulse, which keeps every update aligned to the slow time domain. On a match the block sets a sticky alarm flag and pulses an interrupt request. While an alarm is unacknowledged, or a written configuration has not yet been applied, a sleep-block output stays high so that the device cannot enter its low-power state.

Top module: `rtc_interval_alarm`

## Requirements
- R1: After reset, `alarm_flag_o`, `irq_o` and `sleep_block_o` are all 0 and the timer is disabled.
- R2: A configuration written through `cfg_wr_i` changes nothing until the next `tick_i` pulse. That pulse is the first one that counts under the new settings.
- R3: `cfg_base_i` selects the period that advances the interval counter: 0 = every tick, 1 = every TPS ticks, 2 = every TPS*SPM ticks, 3 = every TPS*SPM*MPH ticks.
- R4: When the count of base periods reaches the interval value, `alarm_flag_o` rises and `irq_o` is high for exactly one clock cycle, on the same edge.
- R5: An interval value of 0 means 256 base periods.
- R6: With `cfg_repeat_i` = 1, a new interval starts at once after each alarm, and the next alarm follows one full interval later.
- R7: With `cfg_repeat_i` = 0, the timer raises one alarm and then stays idle until an enabling configuration is applied again.
- R8: Applying a configuration with `cfg_enable_i` = 0 clears the interval counter and the prescalers, so that a later enable counts a full interval from zero.
- R9: `alarm_flag_o` holds until `ack_i` is high. An alarm on the same edge as `ack_i` wins, and the flag stays set.
- R10: `sleep_block_o` is high whenever the alarm flag is set or a written configuration is waiting for a tick.
- R11: Applying a new interval while the timer stays enabled keeps the current count, and counting continues from that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 128 Hz enable pulse, one clock wide |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_interval_i | input | 8 | Interval in base periods (0 = 256) |
| cfg_base_i | input | 2 | Time base select |
| cfg_enable_i | input | 1 | Timer enable |
| cfg_repeat_i | input | 1 | 1 = repeat, 0 = single shot |
| ack_i | input | 1 | Alarm acknowledge, clears the flag |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | One-cycle interrupt request at each alarm |
| sleep_block_o | output | 1 | High while sleep must be refused |

## Verification
The bench counts the ticks from a configuration write to the first alarm and compares that count with interval times base period. It does this for every time base, with random intervals and modes, and with the 256 case. Several directed sequences each tell one behaviour apart from the others. Interrupting a run with a disable shows whether the counter and the prescalers were really cleared. Rewriting the interval in mid-run shows whether the count is kept or restarted. Waiting without ticks after a write shows whether the new settings are deferred. Running on past an alarm separates repeat mode from single-shot mode.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  typedef enum logic [1:0] {
    BASE_TICK = 2'd0,
    BASE_SEC  = 2'd1,
    BASE_MIN  = 2'd2,
    BASE_HOUR = 2'd3
  } base_e;

  typedef struct packed {
    logic [7:0] interval;
    base_e      base;
    logic       enable;
    logic       repeat_mode;
  } alarm_cfg_t;

  // Picks the period strobe that belongs to the chosen time base.
  function automatic logic pick_strobe(input base_e b, input logic [3:0] stb);
    return stb[b];
  endfunction

  // The 8-bit count wraps, which makes an interval of 0 mean 256 periods.
  function automatic logic [7:0] bump(input logic [7:0] c);
    return c + 8'd1;
  endfunction

  function automatic logic reached(input logic [7:0] nxt, input logic [7:0] iv);
    return nxt == iv;
  endfunction

endpackage

// File: rtl/rtc_cfg_stage.sv
module rtc_cfg_stage
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cfg_wr_i,
  input  alarm_cfg_t cfg_i,
  output alarm_cfg_t eff_o,
  output logic       apply_o,
  output logic       pending_o
);

  alarm_cfg_t staged, applied;
  logic       pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged  <= '0;
      applied <= '0;
      pending <= 1'b0;
    end else begin
      if (tick_i && pending) applied <= staged;
      if (cfg_wr_i) begin
        staged  <= cfg_i;
        pending <= 1'b1;
      end else if (tick_i) begin
        pending <= 1'b0;
      end
    end
  end

  // On the tick that applies a staged word, the new settings already count.
  assign eff_o     = pending ? staged : applied;
  assign apply_o   = tick_i & pending;
  assign pending_o = pending;

  p_pending_drains_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && pending && !cfg_wr_i) |=> !pending);
  p_write_stages_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> pending);

endmodule

// File: rtl/rtc_base_prescaler.sv
module rtc_base_prescaler #(
  parameter int TPS = 128,
  parameter int SPM = 60,
  parameter int MPH = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       run_i,
  output logic [3:0] strobe_o
);

  localparam int NSTAGE = 3;

  function automatic int stage_limit(input int s);
    case (s)
      0:       return TPS;
      1:       return SPM;
      default: return MPH;
    endcase
  endfunction

  logic [NSTAGE:0] carry;
  assign carry[0] = tick_i & run_i;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int L = stage_limit(s);
    localparam int W = (L > 1) ? $clog2(L) : 1;
    logic [W-1:0] cnt;
    logic         wrap;
    assign wrap = (int'(cnt) == L - 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (tick_i && !run_i) cnt <= '0;
      else if (carry[s])         cnt <= wrap ? '0 : cnt + W'(1);
    end

    assign carry[s+1] = carry[s] & wrap;

    p_stage_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < L);
  end

  assign strobe_o = carry;

endmodule

// File: rtl/rtc_interval_counter.sv
module rtc_interval_counter
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       apply_i,
  input  alarm_cfg_t cfg_i,
  input  logic [3:0] strobe_i,
  output logic       hit_o
);

  logic [7:0] cnt, nxt;
  logic       armed, run_now, step;

  assign run_now = apply_i | armed;
  assign step    = tick_i & cfg_i.enable & run_now & pick_strobe(cfg_i.base, strobe_i);
  assign nxt     = bump(cnt);
  assign hit_o   = step & reached(nxt, cfg_i.interval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (tick_i) begin
      if (!cfg_i.enable) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        armed <= run_now;
        if (hit_o) begin
          cnt <= '0;
          if (!cfg_i.repeat_mode) armed <= 1'b0;
        end else if (step) begin
          cnt <= nxt;
        end
      end
    end
  end

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt));
  p_disable_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cfg_i.enable) |=> (cnt == 8'd0));
  p_single_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !cfg_i.repeat_mode) |=> !armed);
  p_repeat_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (cnt == 8'd0));

endmodule

// File: rtl/rtc_interval_alarm.sv
module rtc_interval_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int TPS = 128,
  parameter int SPM = 60,
  parameter int MPH = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_interval_i,
  input  logic [1:0] cfg_base_i,
  input  logic       cfg_enable_i,
  input  logic       cfg_repeat_i,
  input  logic       ack_i,
  output logic       alarm_flag_o,
  output logic       irq_o,
  output logic       sleep_block_o
);

  alarm_cfg_t wr_cfg, eff_cfg;
  logic       apply, pending, hit;
  logic [3:0] strobes;

  assign wr_cfg = '{interval:    cfg_interval_i,
                    base:        base_e'(cfg_base_i),
                    enable:      cfg_enable_i,
                    repeat_mode: cfg_repeat_i};

  rtc_cfg_stage i_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .cfg_wr_i (cfg_wr_i),
    .cfg_i    (wr_cfg),
    .eff_o    (eff_cfg),
    .apply_o  (apply),
    .pending_o(pending)
  );

  rtc_base_prescaler #(.TPS(TPS), .SPM(SPM), .MPH(MPH)) i_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .run_i   (eff_cfg.enable),
    .strobe_o(strobes)
  );

  rtc_interval_counter i_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .apply_i (apply),
    .cfg_i   (eff_cfg),
    .strobe_i(strobes),
    .hit_o   (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag_o <= 1'b0;
      irq_o        <= 1'b0;
    end else begin
      irq_o <= hit;
      if (hit)        alarm_flag_o <= 1'b1;
      else if (ack_i) alarm_flag_o <= 1'b0;
    end
  end

  assign sleep_block_o = alarm_flag_o | pending;

  p_irq_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> alarm_flag_o);
  p_flag_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag_o) |-> irq_o);
  p_flag_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_flag_o) |-> $past(ack_i));
  p_hit_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !irq_o);

endmodule

// File: tb/test_rtc_interval_alarm.sv
module test_rtc_interval_alarm;

  localparam int TPS = 4;
  localparam int SPM = 3;
  localparam int MPH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [7:0] cfg_interval_i = '0;
  logic [1:0] cfg_base_i = '0;
  logic       cfg_enable_i = 1'b0;
  logic       cfg_repeat_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       alarm_flag_o, irq_o, sleep_block_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit last_irq;

  always #4 clk = ~clk;

  rtc_interval_alarm #(.TPS(TPS), .SPM(SPM), .MPH(MPH)) i_rtc_interval_alarm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
    .cfg_interval_i(cfg_interval_i), .cfg_base_i(cfg_base_i),
    .cfg_enable_i(cfg_enable_i), .cfg_repeat_i(cfg_repeat_i), .ack_i(ack_i),
    .alarm_flag_o(alarm_flag_o), .irq_o(irq_o), .sleep_block_o(sleep_block_o)
  );

  function automatic int period(input int b);
    case (b)
      0:       return 1;
      1:       return TPS;
      2:       return TPS * SPM;
      default: return MPH * SPM * TPS;
    endcase
  endfunction

  function automatic int span(input int iv, input int b);
    return ((iv == 0) ? 256 : iv) * period(b);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic write_cfg(input int iv, input int b, input bit en, input bit rp);
    @(negedge clk);
    cfg_interval_i = 8'(iv);
    cfg_base_i     = 2'(b);
    cfg_enable_i   = en;
    cfg_repeat_i   = rp;
    cfg_wr_i       = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic pulse_tick(input bit with_ack);
    @(negedge clk);
    tick_i = 1'b1;
    ack_i  = with_ack;
    @(negedge clk);
    tick_i   = 1'b0;
    ack_i    = 1'b0;
    last_irq = irq_o;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse_tick(1'b0);
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic run_until_alarm(input int max_ticks, output int n);
    n = 0;
    while (n < max_ticks && !alarm_flag_o) begin
      pulse_tick(1'b0);
      n++;
    end
  endtask

  task automatic idle_clean();
    write_cfg(0, 0, 1'b0, 1'b0);
    pulse_tick(1'b0);
    do_ack();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 flag", int'(alarm_flag_o), 0);
    check_eq("R1 irq", int'(irq_o), 0);
    check_eq("R1 sleep_block", int'(sleep_block_o), 0);

    // R2 and R10: a staged write is deferred and holds off sleep
    write_cfg(1, 0, 1'b1, 1'b0);
    check_eq("R10 sleep_block with staged cfg", int'(sleep_block_o), 1);
    repeat (10) @(negedge clk);
    check_eq("R2 no alarm before tick", int'(alarm_flag_o), 0);
    pulse_tick(1'b0);
    check_eq("R4 flag after first tick", int'(alarm_flag_o), 1);
    check_eq("R4 irq on alarm edge", int'(last_irq), 1);
    check_eq("R4 irq one cycle", int'(irq_o), 0);
    check_eq("R10 sleep_block with flag", int'(sleep_block_o), 1);
    repeat (3) @(negedge clk);
    check_eq("R9 flag sticky", int'(alarm_flag_o), 1);
    do_ack();
    check_eq("R9 flag cleared by ack", int'(alarm_flag_o), 0);
    check_eq("R10 sleep_block released", int'(sleep_block_o), 0);

    // R7 single shot
    write_cfg(2, 0, 1'b1, 1'b0);
    run_until_alarm(50, n);
    check_eq("R7 single-shot interval", n, 2);
    do_ack();
    ticks(10);
    check_eq("R7 no second alarm", int'(alarm_flag_o), 0);

    // R6 repeat
    write_cfg(3, 0, 1'b1, 1'b1);
    run_until_alarm(50, n);
    check_eq("R6 first interval", n, 3);
    do_ack();
    run_until_alarm(50, n);
    check_eq("R6 second interval", n, 3);
    idle_clean();

    // R8 disable clears the counter
    write_cfg(5, 0, 1'b1, 1'b1);
    ticks(3);
    write_cfg(5, 0, 1'b0, 1'b1);
    pulse_tick(1'b0);
    write_cfg(5, 0, 1'b1, 1'b1);
    run_until_alarm(50, n);
    check_eq("R8 counter restarted", n, 5);
    idle_clean();

    // R8 disable clears the prescaler
    write_cfg(1, 1, 1'b1, 1'b0);
    ticks(2);
    write_cfg(1, 1, 1'b0, 1'b0);
    pulse_tick(1'b0);
    write_cfg(1, 1, 1'b1, 1'b0);
    run_until_alarm(50, n);
    check_eq("R8 prescaler restarted", n, TPS);
    idle_clean();

    // R11 new interval while enabled keeps the count
    write_cfg(10, 0, 1'b1, 1'b1);
    ticks(3);
    write_cfg(5, 0, 1'b1, 1'b1);
    run_until_alarm(50, n);
    check_eq("R11 count kept", n, 2);
    idle_clean();

    // R5 interval 0 means 256
    write_cfg(0, 0, 1'b1, 1'b0);
    run_until_alarm(300, n);
    check_eq("R5 interval zero", n, 256);
    idle_clean();

    // R3 every time base, directed
    for (int b = 1; b < 4; b++) begin
      write_cfg(2, b, 1'b1, 1'b0);
      run_until_alarm(200, n);
      check_eq("R3 directed base", n, span(2, b));
      idle_clean();
    end

    // R3 random interval, base and mode
    for (int k = 0; k < 8; k++) begin
      int iv, b;
      bit rp;
      iv = 1 + int'($urandom_range(0, 5));
      b  = int'($urandom_range(0, 3));
      rp = 1'($urandom_range(0, 1));
      write_cfg(iv, b, 1'b1, rp);
      run_until_alarm(200, n);
      check_eq("R3 random base", n, span(iv, b));
      idle_clean();
    end

    // R9 an alarm on the same edge as ack wins
    write_cfg(2, 0, 1'b1, 1'b0);
    pulse_tick(1'b0);
    pulse_tick(1'b1);
    check_eq("R9 set wins over ack", int'(alarm_flag_o), 1);
    do_ack();
    check_eq("R9 cleared afterwards", int'(alarm_flag_o), 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule